// File: doc/BRIEF.md
# Two-Channel DMA Control and Status Register File

This block is the software-visible register file of a two-channel scatter-gather DMA engine. Channel 0 moves data from memory to a stream, and channel 1 moves data from a stream to memory. A simple 32-bit register bus reads and writes whole words. The byte address space is split into 0x30-byte windows, and the windows alternate between channel 0 and channel 1. Each window holds four registers: control, status, current descriptor pointer and tail descriptor pointer. Every other word in the window is plain read/write storage.

The descriptor engine and the completion-coalescing logic sit outside this block. They receive run, soft-reset, start, pointer and coalescing-reload controls from it. They send back halt, idle, complete-event and delay-event pulses, and the live coalescing count and delay timer values. When status is read, those live values are merged into the returned word. Each channel drives one interrupt line. The line is high when a pending event bit in status is also enabled by the matching bit in control.

Top module: `dma_csr_top`

## Requirements
- R1: After reset, control reads 0x0001_0000 and status bits 15:0 read 0x0001 (halted). irq_o, run_o, soft_rst_o and start_o are all 0.
- R2: The channel is bit 0 of floor(addr_i / 0x30), and the register is (addr_i mod 0x30) / 4. Word 0 is control, word 1 is status, word 2 is the current descriptor and word 4 is the tail descriptor. Every other word in the window reads back its last written value, and windows of the same channel alias.
- R3: A control write stores the written value with bit 1 forced to 1 and bit 2 OR-ed with its previous value. run_o shows control bit 0 and soft_rst_o shows control bit 2.
- R4: A control read returns the stored value with bit 2 cleared, and also clears the stored bit 2.
- R5: A control write whose resulting bit 2 is 1 sets status bits 15:0 to 0x0001.
- R6: A control write with bit 0 set and resulting bit 2 clear clears status bits 0 (halted) and 1 (idle).
- R7: A status write clears the pending bits 14:12 where the written data holds a 1. It stores written bits 15 and 11:0 as given. Written bits 31:16 are dropped.
- R8: A status read returns {dly_cnt, coal_cnt, status[15:0]}, with dly_cnt in bits 31:24 and coal_cnt in bits 23:16, taken from the channel's input slices.
- R9: irq_o of a channel is the OR of status[14:12] AND control[14:12]. It changes in the cycle after the register changes.
- R10: Event inputs set status bits: halt sets bit 0, idle sets bit 1, complete sets bit 12 and delay sets bit 13. An event wins over a register write to the same bit in the same cycle.
- R11: A tail descriptor write clears the idle bit. On channel 0 it also raises start_o for exactly one cycle after the write. A channel 1 tail write leaves start_o at 0.
- R12: Every control write raises the channel's coal_reload_o for one cycle after the write. coal_thresh_o always shows control bits 23:16.
- R13: A read request yields rdata_o with rvalid_o high in the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| irq_o | output | 2 | Interrupt per channel |
| run_o | output | 2 | Run bit per channel |
| soft_rst_o | output | 2 | Soft reset bit per channel |
| start_o | output | 1 | Transmit-channel start pulse |
| coal_reload_o | output | 2 | Coalescing counter reload pulse per channel |
| coal_thresh_o | output | 16 | Coalescing threshold, 8 bits per channel |
| cur_desc_o | output | 64 | Current descriptor pointer, 32 bits per channel |
| tail_desc_o | output | 64 | Tail descriptor pointer, 32 bits per channel |
| halt_set_i | input | 2 | Halted event per channel |
| idle_set_i | input | 2 | Idle event per channel |
| ioc_set_i | input | 2 | Completion event per channel |
| dly_set_i | input | 2 | Delay-timer event per channel |
| coal_cnt_i | input | 16 | Live coalescing count, 8 bits per channel |
| dly_cnt_i | input | 16 | Live delay timer value, 8 bits per channel |

## Verification
Most faults in this block are lost state bits, and they show at the ports within one cycle. A reset bit that never clears keeps soft_rst_o high after the next control read. A status register that drops a pending bit, or keeps one it should have cleared, makes irq_o disagree in the cycle after the write. A wrong window decode makes a later read of the aliased or the neighbouring channel return a value the reference model does not expect. The random phase runs soft resets, event pulses and writes to both the mapped and the unmapped words. Because of that, a wrong priority between an event and a write, or a wrong bit kept by a write, is exposed at the next read of that channel.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int unsigned NUM_CH       = 2;
  localparam int unsigned CH_WIN_BYTES = 48;
  localparam int unsigned WIDX_W       = 4;
  localparam int unsigned WORDS        = 2 ** WIDX_W;

  localparam int unsigned CTRL_IDX = 0;
  localparam int unsigned STS_IDX  = 1;
  localparam int unsigned CUR_IDX  = 2;
  localparam int unsigned TAIL_IDX = 4;

  localparam int unsigned RUN_BIT   = 0;
  localparam int unsigned TPM_BIT   = 1;
  localparam int unsigned SRST_BIT  = 2;
  localparam int unsigned HALT_BIT  = 0;
  localparam int unsigned IDLE_BIT  = 1;
  localparam int unsigned IOC_BIT   = 12;
  localparam int unsigned DLY_BIT   = 13;
  localparam int unsigned IRQ_LSB   = 12;
  localparam int unsigned IRQ_W     = 3;
  localparam int unsigned THR_LSB   = 16;

  localparam logic [31:0] CTRL_RST = 32'h0001_0000;
  localparam logic [15:0] STS_RST  = 16'h0001;

  typedef struct packed {
    logic halt;
    logic idle;
    logic ioc;
    logic dly;
  } dma_evt_t;

  function automatic logic [31:0] sts_word(logic [7:0] dly, logic [7:0] coal, logic [15:0] sts);
    return {dly, coal, sts};
  endfunction
endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode
  import dma_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  output logic                  ch_o,
  output logic [WIDX_W-1:0]     widx_o,
  output logic [NUM_CH-1:0]     wr_en_o,
  output logic [NUM_CH-1:0]     rd_en_o
);
  assign ch_o   = 1'(addr_i / ADDR_W'(CH_WIN_BYTES));
  assign widx_o = WIDX_W'((addr_i % ADDR_W'(CH_WIN_BYTES)) >> 2);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign wr_en_o[c] = req_i &&  we_i && (ch_o == 1'(c));
    assign rd_en_o[c] = req_i && !we_i && (ch_o == 1'(c));
  end
endmodule

// File: rtl/dma_csr_chan.sv
module dma_csr_chan
  import dma_csr_pkg::*;
#(
  parameter bit IS_TX = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [WIDX_W-1:0] widx_i,
  input  logic [31:0]       wdata_i,
  input  dma_evt_t          evt_i,
  input  logic [7:0]        coal_cnt_i,
  input  logic [7:0]        dly_cnt_i,
  output logic [31:0]       rd_word_o,
  output logic              irq_o,
  output logic              run_o,
  output logic              soft_rst_o,
  output logic              start_o,
  output logic              coal_reload_o,
  output logic [7:0]        coal_thresh_o,
  output logic [31:0]       cur_desc_o,
  output logic [31:0]       tail_desc_o
);
  logic [31:0] ctrl_q, ctrl_d;
  logic [15:0] sts_q, sts_d;
  logic [31:0] word_q [WORDS];
  logic        ctrl_wr, ctrl_rd, sts_wr, tail_wr;
  logic [31:0] ctrl_new;

  assign ctrl_wr = wr_en_i && (widx_i == WIDX_W'(CTRL_IDX));
  assign ctrl_rd = rd_en_i && (widx_i == WIDX_W'(CTRL_IDX));
  assign sts_wr  = wr_en_i && (widx_i == WIDX_W'(STS_IDX));
  assign tail_wr = wr_en_i && (widx_i == WIDX_W'(TAIL_IDX));

  // tail-pointer mode pinned, pending soft reset survives the write
  assign ctrl_new = wdata_i | (32'd1 << TPM_BIT) | (ctrl_q & (32'd1 << SRST_BIT));

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr)      ctrl_d = ctrl_new;
    else if (ctrl_rd) ctrl_d[SRST_BIT] = 1'b0;
  end

  always_comb begin
    sts_d = sts_q;
    if (ctrl_wr) begin
      if (ctrl_new[SRST_BIT]) begin
        sts_d = STS_RST;
      end else if (ctrl_new[RUN_BIT]) begin
        sts_d[HALT_BIT] = 1'b0;
        sts_d[IDLE_BIT] = 1'b0;
      end
    end
    if (sts_wr) begin
      sts_d = wdata_i[15:0];
      sts_d[IRQ_LSB +: IRQ_W] = sts_q[IRQ_LSB +: IRQ_W] & ~wdata_i[IRQ_LSB +: IRQ_W];
    end
    if (tail_wr) sts_d[IDLE_BIT] = 1'b0;
    // hardware events take priority over same-cycle bus updates
    if (evt_i.halt) sts_d[HALT_BIT] = 1'b1;
    if (evt_i.idle) sts_d[IDLE_BIT] = 1'b1;
    if (evt_i.ioc)  sts_d[IOC_BIT]  = 1'b1;
    if (evt_i.dly)  sts_d[DLY_BIT]  = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q        <= CTRL_RST;
      sts_q         <= STS_RST;
      coal_reload_o <= 1'b0;
    end else begin
      ctrl_q        <= ctrl_d;
      sts_q         <= sts_d;
      coal_reload_o <= ctrl_wr;
    end
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    if (i == CTRL_IDX || i == STS_IDX) begin : g_none
      assign word_q[i] = '0;
    end else begin : g_store
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                   word_q[i] <= '0;
        else if (wr_en_i && widx_i == WIDX_W'(i))      word_q[i] <= wdata_i;
      end
    end
  end

  if (IS_TX) begin : g_tx
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) start_o <= 1'b0;
      else         start_o <= tail_wr;
    end
  end else begin : g_rx
    assign start_o = 1'b0;
  end

  always_comb begin
    case (widx_i)
      WIDX_W'(CTRL_IDX): rd_word_o = ctrl_q & ~(32'd1 << SRST_BIT);
      WIDX_W'(STS_IDX):  rd_word_o = sts_word(dly_cnt_i, coal_cnt_i, sts_q);
      default:           rd_word_o = word_q[widx_i];
    endcase
  end

  assign irq_o         = |(sts_q[IRQ_LSB +: IRQ_W] & ctrl_q[IRQ_LSB +: IRQ_W]);
  assign run_o         = ctrl_q[RUN_BIT];
  assign soft_rst_o    = ctrl_q[SRST_BIT];
  assign coal_thresh_o = ctrl_q[THR_LSB +: 8];
  assign cur_desc_o    = word_q[CUR_IDX];
  assign tail_desc_o   = word_q[TAIL_IDX];

  a_r3_tpm_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> ctrl_q[TPM_BIT]);
  a_r4_srst_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rd |=> !soft_rst_o);
  a_r5_srst_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wdata_i[SRST_BIT] && !evt_i.idle && !evt_i.ioc && !evt_i.dly)
      |=> (sts_q == STS_RST));
  a_r7_w1c_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr && (&wdata_i[IRQ_LSB +: IRQ_W]) && !evt_i.ioc && !evt_i.dly) |=> !irq_o);
  a_r10_halt_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.halt |=> sts_q[HALT_BIT]);
  a_r11_tail_clears_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tail_wr && !evt_i.idle) |=> !sts_q[IDLE_BIT]);
  a_r12_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> (coal_reload_o && coal_thresh_o == $past(wdata_i[THR_LSB +: 8])));
  if (IS_TX) begin : g_tx_chk
    a_r11_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tail_wr |=> start_o);
  end
endmodule

// File: rtl/dma_csr_top.sv
module dma_csr_top
  import dma_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic                rvalid_o,
  output logic [31:0]         rdata_o,
  output logic [1:0]          irq_o,
  output logic [1:0]          run_o,
  output logic [1:0]          soft_rst_o,
  output logic                start_o,
  output logic [1:0]          coal_reload_o,
  output logic [15:0]         coal_thresh_o,
  output logic [63:0]         cur_desc_o,
  output logic [63:0]         tail_desc_o,
  input  logic [1:0]          halt_set_i,
  input  logic [1:0]          idle_set_i,
  input  logic [1:0]          ioc_set_i,
  input  logic [1:0]          dly_set_i,
  input  logic [15:0]         coal_cnt_i,
  input  logic [15:0]         dly_cnt_i
);
  logic                ch_sel;
  logic [WIDX_W-1:0]   widx;
  logic [NUM_CH-1:0]   wr_en, rd_en, start_w;
  logic [31:0]         rd_word_w [NUM_CH];
  dma_evt_t            evt_w [NUM_CH];

  dma_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .ch_o    (ch_sel),
    .widx_o  (widx),
    .wr_en_o (wr_en),
    .rd_en_o (rd_en)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign evt_w[c] = '{halt: halt_set_i[c], idle: idle_set_i[c],
                        ioc: ioc_set_i[c], dly: dly_set_i[c]};
    dma_csr_chan #(.IS_TX(c == 0)) u_chan (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .wr_en_i       (wr_en[c]),
      .rd_en_i       (rd_en[c]),
      .widx_i        (widx),
      .wdata_i       (wdata_i),
      .evt_i         (evt_w[c]),
      .coal_cnt_i    (coal_cnt_i[8*c +: 8]),
      .dly_cnt_i     (dly_cnt_i[8*c +: 8]),
      .rd_word_o     (rd_word_w[c]),
      .irq_o         (irq_o[c]),
      .run_o         (run_o[c]),
      .soft_rst_o    (soft_rst_o[c]),
      .start_o       (start_w[c]),
      .coal_reload_o (coal_reload_o[c]),
      .coal_thresh_o (coal_thresh_o[8*c +: 8]),
      .cur_desc_o    (cur_desc_o[32*c +: 32]),
      .tail_desc_o   (tail_desc_o[32*c +: 32])
    );
  end

  assign start_o = |start_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= req_i && !we_i;
      if (req_i && !we_i) rdata_o <= rd_word_w[ch_sel];
    end
  end

  a_r13_rvalid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  a_r13_rvalid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);
  a_r11_start_tx_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_w) && !start_w[1]);
endmodule

// File: tb/dma_csr_top_tb.sv
module dma_csr_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        rvalid_o;
  logic [31:0] rdata_o;
  logic [1:0]  irq_o, run_o, soft_rst_o, coal_reload_o;
  logic        start_o;
  logic [15:0] coal_thresh_o;
  logic [63:0] cur_desc_o, tail_desc_o;
  logic [1:0]  halt_set_i = '0, idle_set_i = '0, ioc_set_i = '0, dly_set_i = '0;
  logic [15:0] coal_cnt_i = 16'hB2A1;
  logic [15:0] dly_cnt_i  = 16'h7C3D;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_ctrl [2];
  logic [15:0] m_sts  [2];
  logic [31:0] m_word [2][12];
  logic [1:0]  exp_reload;
  logic        exp_start;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_csr_top #(.ADDR_W(8)) u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ch_of(int a); return (a / 48) % 2; endfunction
  function automatic int idx_of(int a); return (a % 48) / 4; endfunction

  function automatic void m_write(int a, logic [31:0] d);
    int c = ch_of(a);
    int i = idx_of(a);
    logic [31:0] v;
    logic [15:0] s;
    case (i)
      0: begin
        v = d | 32'h2 | (m_ctrl[c] & 32'h4);
        m_ctrl[c] = v;
        if (v[2]) m_sts[c] = 16'h0001;
        else if (v[0]) m_sts[c][1:0] = 2'b00;
        exp_reload[c] = 1'b1;
      end
      1: begin
        s = d[15:0];
        s[14:12] = m_sts[c][14:12] & ~d[14:12];
        m_sts[c] = s;
      end
      default: begin
        m_word[c][i] = d;
        if (i == 4) begin
          m_sts[c][1] = 1'b0;
          if (c == 0) exp_start = 1'b1;
        end
      end
    endcase
  endfunction

  function automatic void m_event(int c, logic [3:0] ev);
    if (ev[0]) m_sts[c][0]  = 1'b1;
    if (ev[1]) m_sts[c][1]  = 1'b1;
    if (ev[2]) m_sts[c][12] = 1'b1;
    if (ev[3]) m_sts[c][13] = 1'b1;
  endfunction

  function automatic logic [31:0] m_read(int a);
    int c = ch_of(a);
    int i = idx_of(a);
    logic [31:0] r;
    case (i)
      0: begin r = m_ctrl[c] & ~32'h4; m_ctrl[c][2] = 1'b0; end
      1: r = {dly_cnt_i[8*c +: 8], coal_cnt_i[8*c +: 8], m_sts[c]};
      default: r = m_word[c][i];
    endcase
    return r;
  endfunction

  task automatic chk_static();
    for (int c = 0; c < 2; c++) begin
      chk("R9 irq",  32'(irq_o[c]), 32'(|(m_sts[c][14:12] & m_ctrl[c][14:12])));
      chk("R3 run",  32'(run_o[c]), 32'(m_ctrl[c][0]));
      chk("R3 srst", 32'(soft_rst_o[c]), 32'(m_ctrl[c][2]));
      chk("R12 thresh", 32'(coal_thresh_o[8*c +: 8]), 32'(m_ctrl[c][23:16]));
    end
  endtask

  task automatic set_ev(int c, logic [3:0] ev);
    halt_set_i = '0; idle_set_i = '0; ioc_set_i = '0; dly_set_i = '0;
    halt_set_i[c] = ev[0]; idle_set_i[c] = ev[1];
    ioc_set_i[c]  = ev[2]; dly_set_i[c]  = ev[3];
  endtask

  task automatic wr(int a, logic [31:0] d, int ec = 0, logic [3:0] ev = 4'h0);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = 8'(a); wdata_i = d;
    set_ev(ec, ev);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    set_ev(0, 4'h0);
    exp_reload = '0; exp_start = 1'b0;
    m_write(a, d);
    m_event(ec, ev);
    chk("R12 reload", 32'(coal_reload_o), 32'(exp_reload));
    chk("R11 start", 32'(start_o), 32'(exp_start));
    chk_static();
  endtask

  task automatic evt(int c, logic [3:0] ev);
    @(negedge clk_i);
    set_ev(c, ev);
    @(negedge clk_i);
    set_ev(0, 4'h0);
    m_event(c, ev);
    chk_static();
  endtask

  task automatic rd(int a, string req);
    logic [31:0] e;
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = 8'(a);
    @(negedge clk_i);
    req_i = 1'b0;
    e = m_read(a);
    chk("R13 rvalid", 32'(rvalid_o), 32'h1);
    chk(req, rdata_o, e);
    chk_static();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < 2; c++) begin
      m_ctrl[c] = 32'h0001_0000;
      m_sts[c]  = 16'h0001;
      for (int i = 0; i < 12; i++) m_word[c][i] = '0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 irq", 32'(irq_o), 32'h0);
    chk("R1 run", 32'(run_o), 32'h0);
    chk("R1 srst", 32'(soft_rst_o), 32'h0);
    chk("R1 start", 32'(start_o), 32'h0);
    rd(8'h00, "R1 ctrl0");
    rd(8'h04, "R1 sts0");
    rd(8'h34, "R1 sts1 R8");

    // R2 decode and aliasing
    wr(8'h0C, 32'hDEAD_0001);
    wr(8'h3C, 32'hBEEF_0002);
    rd(8'h6C, "R2 alias ch0");
    rd(8'h9C, "R2 alias ch1");
    wr(8'h38, 32'h1234_5678);
    chk("R2 cur1", cur_desc_o[63:32], 32'h1234_5678);
    rd(8'h08, "R2 cur0 untouched");

    // R3..R6 soft reset handling on ch1
    wr(8'h30, 32'h0000_0000);
    rd(8'h30, "R3 tpm forced");
    wr(8'h30, 32'h0000_0004);
    chk("R3 srst held", 32'(soft_rst_o[1]), 32'h1);
    wr(8'h30, 32'h0000_0001);
    chk("R3 srst kept", 32'(soft_rst_o[1]), 32'h1);
    rd(8'h34, "R5 halted during reset");
    rd(8'h30, "R4 read clears srst");
    chk("R4 srst low", 32'(soft_rst_o[1]), 32'h0);
    evt(1, 4'b0011);
    wr(8'h30, 32'h0000_0001);
    rd(8'h34, "R6 run clears halt idle");

    // R7 R9 R10 interrupt path on ch1
    evt(1, 4'b1100);
    rd(8'h34, "R10 events set");
    wr(8'h30, 32'h0005_1001);
    chk("R9 irq on", 32'(irq_o[1]), 32'h1);
    wr(8'h34, 32'hFFFF_1000);
    chk("R7 w1c irq off", 32'(irq_o[1]), 32'h0);
    rd(8'h34, "R7 dly kept");
    wr(8'h34, 32'h0000_2000, 1, 4'b1000);
    rd(8'h34, "R10 event beats w1c");

    // R11 tail writes
    evt(0, 4'b0010);
    wr(8'h10, 32'h0000_4000);
    chk("R11 tail0", tail_desc_o[31:0], 32'h0000_4000);
    rd(8'h04, "R11 idle cleared ch0");
    evt(1, 4'b0010);
    wr(8'h40, 32'h0000_8000);
    rd(8'h34, "R11 idle cleared ch1");

    // R12 threshold reload
    wr(8'h00, 32'h00A5_0000);
    chk("R12 thr0", 32'(coal_thresh_o[7:0]), 32'hA5);

    // R13 rvalid drops
    rd(8'h00, "R13 data");
    @(negedge clk_i);
    chk("R13 rvalid low", 32'(rvalid_o), 32'h0);

    // random phase
    for (int k = 0; k < 600; k++) begin
      int op = $urandom % 4;
      int a  = int'(($urandom % 64) * 4);
      logic [31:0] d = $urandom;
      case (op)
        0, 1: wr(a, d, int'($urandom % 2), 4'($urandom % 16 == 0 ? $urandom : 0));
        2: rd(a, idx_of(a) == 0 ? "R4 rand ctrl" : idx_of(a) == 1 ? "R8 rand sts" : "R2 rand word");
        default: evt(int'($urandom % 2), 4'($urandom));
      endcase
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule